// File: doc/BRIEF.md
# Jump-Counter Microprogram Sequencer

This block is the control unit of a small multicycle processor. It steps a 4-bit micro-program counter through a hard-coded microcode store, and it puts the control points of the current microinstruction on its outputs. The datapath sits outside the block and acts on these points at each clock edge. Each microinstruction carries a sequencing field and the datapath fields. The sequencing field picks one of three moves: step the counter by one, clear it to the fetch address, or jump to an address that a dispatch table gives for the current opcode.

Five instructions are supported: a register-register operation, an immediate OR, a word load, a word store and a branch on equality. Every instruction starts with a fetch step (FETCH, 0000) and a decode step (DECODE, 0001). DECODE dispatches to the execute steps. The register operation runs RT_EXE (0100) and RT_WB (0101). The immediate OR runs OR_EXE (0110) and OR_WB (0111). The load runs LD_EXE (1000), LD_MEM (1001) and LD_WB (1010). The store runs ST_EXE (1011) and ST_MEM (1100). The branch uses the single step BRANCH (0011).

The transitions are: FETCH to DECODE; DECODE to the dispatched step; each EXE step to the next step; LD_MEM to LD_WB; and every final step (BRANCH, RT_WB, OR_WB, LD_WB, ST_MEM) back to FETCH. The steps that touch memory are FETCH, LD_MEM and ST_MEM. In these steps a high memory-busy input holds the counter, and every register and memory write is suppressed. The unused addresses 0010 and 1101 to 1111 return to FETCH and drive no enables.

Top module: `ucseq_top`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0000 at that edge. In 0000, only `ir_en` is high.
- R2: When no wait is in force, the counter steps by one from 0000, 0100, 0110, 1000, 1001 and 1011.
- R3: In 0001 the next address comes from `opcode`: 000000 goes to 0100, 000100 to 0011, 001101 to 0110, 100011 to 1000, 101011 to 1011, and any other value goes to 0000.
- R4: The final steps 0011, 0101, 0111, 1010 and 1100 go to 0000 at the next edge. For 1100 this holds only when no wait is in force.
- R5: In 0011, `pc_en` is high and `pc_sel` equals `eq`. A value of 1 selects the branch target and 0 selects PC + 4.
- R6: While `mem_busy` is high in 0000, 1001 or 1100, `upc` holds its value.
- R7: During such a wait, `ir_en`, `pc_en`, `a_en`, `b_en`, `e_en`, `s_en`, `m_en`, `reg_wr` and `mem_wr` are all 0.
- R8: `mem_busy` has no effect on the sequence or on the control word in any other address.
- R9: Each step drives its own control word. 0001 raises `a_en`, `b_en` and `e_en`. The EXE steps raise `s_en` with `alu_op` set as follows: 10 for the function field in 0100, 01 for OR with `ext_sign`=0 in 0110, and 00 for add with `ext_sign`=1 in 1000 and 1011. 1001 raises `m_en`. The write-backs raise `pc_en` and `reg_wr`, with `reg_dst`=1 (rd) only in 0101 and `mem_to_reg`=1 only in 1010. 1100 raises `pc_en` and `mem_wr`. Every field not named here is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| eq | input | 1 | Operand equality flag from the datapath |
| mem_busy | input | 1 | Memory not ready this cycle |
| upc | output | 4 | Current micro-program counter |
| ir_en | output | 1 | Instruction register load |
| pc_en | output | 1 | Program counter load |
| pc_sel | output | 1 | 1: branch target, 0: PC + 4 |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| e_en | output | 1 | Equality register load |
| s_en | output | 1 | ALU result register load |
| m_en | output | 1 | Memory data register load |
| alu_op | output | 2 | 00 add, 01 or, 10 function field |
| ext_sign | output | 1 | 1 sign-extend, 0 zero-extend immediate |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | 1: rd, 0: rt as write target |
| mem_wr | output | 1 | Data memory write |
| mem_to_reg | output | 1 | 1: write-back from memory data |

## Verification
Assertions check the following on every cycle: the counter stepping, the dispatch landing on a legal first step, each final step returning to fetch, the branch select following `eq`, and the hold of the counter with all writes off during a memory wait. Only the bench's scenarios can show the following: that each opcode lands on its own address, that a full trace produces the exact control word in each step, that `mem_busy` outside the memory steps changes nothing, and that reset in the middle of an instruction returns to fetch.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int UPC_W = 4;
    localparam int OPC_W = 6;

    typedef enum logic [1:0] {
        SQ_HOLD = 2'b00,
        SQ_INC  = 2'b01,
        SQ_ZERO = 2'b10,
        SQ_LOAD = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_FUNC = 2'b10
    } alu_e;

    typedef enum logic [UPC_W-1:0] {
        U_FETCH  = 4'd0,
        U_DECODE = 4'd1,
        U_BRANCH = 4'd3,
        U_RT_EXE = 4'd4,
        U_RT_WB  = 4'd5,
        U_OR_EXE = 4'd6,
        U_OR_WB  = 4'd7,
        U_LD_EXE = 4'd8,
        U_LD_MEM = 4'd9,
        U_LD_WB  = 4'd10,
        U_ST_EXE = 4'd11,
        U_ST_MEM = 4'd12
    } uaddr_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

    typedef struct packed {
        logic ir_en;
        logic pc_en;
        logic pc_by_eq;
        logic a_en;
        logic b_en;
        logic e_en;
        logic s_en;
        logic m_en;
        alu_e alu;
        logic ext_sign;
        logic reg_wr;
        logic reg_dst;
        logic mem_wr;
        logic mem_to_reg;
        logic may_wait;
        seq_e seq;
    } uword_t;

endpackage

// File: rtl/ucseq_map.sv
module ucseq_map
    import ucseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output uaddr_e           target
);
    always_comb begin
        case (opcode)
            OPC_RTYPE: target = U_RT_EXE;
            OPC_BEQ:   target = U_BRANCH;
            OPC_ORI:   target = U_OR_EXE;
            OPC_LOAD:  target = U_LD_EXE;
            OPC_STORE: target = U_ST_EXE;
            default:   target = U_FETCH;
        endcase
    end
endmodule

// File: rtl/ucseq_store.sv
module ucseq_store
    import ucseq_pkg::*;
(
    input  uaddr_e addr,
    output uword_t word
);
    always_comb begin
        word     = '0;
        word.alu = ALU_ADD;
        word.seq = SQ_ZERO;
        unique case (addr)
            U_FETCH: begin
                word.ir_en    = 1'b1;
                word.may_wait = 1'b1;
                word.seq      = SQ_INC;
            end
            U_DECODE: begin
                word.a_en = 1'b1;
                word.b_en = 1'b1;
                word.e_en = 1'b1;
                word.seq  = SQ_LOAD;
            end
            U_BRANCH: begin
                word.pc_en    = 1'b1;
                word.pc_by_eq = 1'b1;
            end
            U_RT_EXE: begin
                word.s_en = 1'b1;
                word.alu  = ALU_FUNC;
                word.seq  = SQ_INC;
            end
            U_RT_WB: begin
                word.pc_en   = 1'b1;
                word.reg_wr  = 1'b1;
                word.reg_dst = 1'b1;
            end
            U_OR_EXE: begin
                word.s_en = 1'b1;
                word.alu  = ALU_OR;
                word.seq  = SQ_INC;
            end
            U_OR_WB: begin
                word.pc_en  = 1'b1;
                word.reg_wr = 1'b1;
            end
            U_LD_EXE, U_ST_EXE: begin
                word.s_en     = 1'b1;
                word.ext_sign = 1'b1;
                word.seq      = SQ_INC;
            end
            U_LD_MEM: begin
                word.m_en     = 1'b1;
                word.may_wait = 1'b1;
                word.seq      = SQ_INC;
            end
            U_LD_WB: begin
                word.pc_en      = 1'b1;
                word.reg_wr     = 1'b1;
                word.mem_to_reg = 1'b1;
            end
            U_ST_MEM: begin
                word.pc_en    = 1'b1;
                word.mem_wr   = 1'b1;
                word.may_wait = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
    import ucseq_pkg::*;
(
    input  uaddr_e cur,
    input  seq_e   seq,
    input  uaddr_e target,
    input  logic   stall,
    output uaddr_e nxt
);
    always_comb begin
        if (stall) begin
            nxt = cur;
        end else begin
            unique case (seq)
                SQ_INC:  nxt = uaddr_e'(cur + UPC_W'(1));
                SQ_ZERO: nxt = U_FETCH;
                SQ_LOAD: nxt = target;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
    import ucseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             eq,
    input  logic             mem_busy,
    output logic [UPC_W-1:0] upc,
    output logic             ir_en,
    output logic             pc_en,
    output logic             pc_sel,
    output logic             a_en,
    output logic             b_en,
    output logic             e_en,
    output logic             s_en,
    output logic             m_en,
    output logic [1:0]       alu_op,
    output logic             ext_sign,
    output logic             reg_wr,
    output logic             reg_dst,
    output logic             mem_wr,
    output logic             mem_to_reg
);
    uaddr_e cur;
    uaddr_e nxt;
    uaddr_e target;
    uword_t word;
    logic   stall;

    ucseq_map   u_map   (.opcode(opcode), .target(target));
    ucseq_store u_store (.addr(cur), .word(word));

    assign stall = word.may_wait & mem_busy;

    ucseq_next u_next (
        .cur(cur), .seq(word.seq), .target(target), .stall(stall), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= U_FETCH;
        else     cur <= nxt;
    end

    always_comb begin
        upc        = cur;
        ir_en      = word.ir_en  & ~stall;
        pc_en      = word.pc_en  & ~stall;
        pc_sel     = word.pc_by_eq & eq;
        a_en       = word.a_en   & ~stall;
        b_en       = word.b_en   & ~stall;
        e_en       = word.e_en   & ~stall;
        s_en       = word.s_en   & ~stall;
        m_en       = word.m_en   & ~stall;
        alu_op     = word.alu;
        ext_sign   = word.ext_sign;
        reg_wr     = word.reg_wr & ~stall;
        reg_dst    = word.reg_dst;
        mem_wr     = word.mem_wr & ~stall;
        mem_to_reg = word.mem_to_reg;
    end

    logic mem_step;
    assign mem_step = (upc == 4'd0) || (upc == 4'd9) || (upc == 4'd12);

    assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
        ((upc == 4'd0 || upc == 4'd4 || upc == 4'd6 || upc == 4'd8 ||
          upc == 4'd9 || upc == 4'd11) && !(mem_step && mem_busy))
        |=> (upc == UPC_W'($past(upc) + 1)));

    assert_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd1) |=> (upc == 4'd0 || upc == 4'd3 || upc == 4'd4 ||
                           upc == 4'd6 || upc == 4'd8 || upc == 4'd11));

    assert_finish_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd3 || upc == 4'd5 || upc == 4'd7 || upc == 4'd10 ||
         (upc == 4'd12 && !mem_busy)) |=> (upc == 4'd0));

    assert_branch_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd3) |-> (pc_en && pc_sel == eq));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_step && mem_busy) |=> $stable(upc));

    assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_step && mem_busy) |-> !(ir_en || pc_en || a_en || b_en || e_en ||
                                     s_en || m_en || reg_wr || mem_wr));

    assert_one_writer_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_en, reg_wr, mem_wr}));

endmodule

// File: tb/tb_ucseq_top.sv
module tb_ucseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       eq = 1'b0;
    logic       mem_busy = 1'b0;
    logic [3:0] upc;
    logic ir_en, pc_en, pc_sel, a_en, b_en, e_en, s_en, m_en;
    logic [1:0] alu_op;
    logic ext_sign, reg_wr, reg_dst, mem_wr, mem_to_reg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ucseq_top dut (
        .clk(clk), .rst(rst), .opcode(opcode), .eq(eq), .mem_busy(mem_busy),
        .upc(upc), .ir_en(ir_en), .pc_en(pc_en), .pc_sel(pc_sel),
        .a_en(a_en), .b_en(b_en), .e_en(e_en), .s_en(s_en), .m_en(m_en),
        .alu_op(alu_op), .ext_sign(ext_sign), .reg_wr(reg_wr),
        .reg_dst(reg_dst), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg)
    );

    logic [14:0] cw;
    assign cw = {ir_en, pc_en, pc_sel, a_en, b_en, e_en, s_en, m_en,
                 alu_op, ext_sign, reg_wr, reg_dst, mem_wr, mem_to_reg};

    // {ir pc psel}_{a b e}_{s m}_{alu}_{ext}_{rw rd mw mr}
    localparam logic [14:0] W_IDLE  = 15'b000_000_00_00_0_0000;
    localparam logic [14:0] W_FETCH = 15'b100_000_00_00_0_0000;
    localparam logic [14:0] W_DEC   = 15'b000_111_00_00_0_0000;
    localparam logic [14:0] W_BR1   = 15'b011_000_00_00_0_0000;
    localparam logic [14:0] W_BR0   = 15'b010_000_00_00_0_0000;
    localparam logic [14:0] W_RTEX  = 15'b000_000_10_10_0_0000;
    localparam logic [14:0] W_RTWB  = 15'b010_000_00_00_0_1100;
    localparam logic [14:0] W_OREX  = 15'b000_000_10_01_0_0000;
    localparam logic [14:0] W_ORWB  = 15'b010_000_00_00_0_1000;
    localparam logic [14:0] W_ADEX  = 15'b000_000_10_00_1_0000;
    localparam logic [14:0] W_LDMEM = 15'b000_000_01_00_0_0000;
    localparam logic [14:0] W_LDWB  = 15'b010_000_00_00_0_1001;
    localparam logic [14:0] W_STMEM = 15'b010_000_00_00_0_0010;

    localparam int NV = 30;
    // {opcode, eq, mem_busy, expected upc, expected control word}
    localparam logic [26:0] VEC [0:NV-1] = '{
        {6'b000000, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b000000, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b000000, 1'b1, 1'b1, 4'd4,  W_RTEX},
        {6'b000000, 1'b0, 1'b1, 4'd5,  W_RTWB},
        {6'b001101, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b001101, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b001101, 1'b0, 1'b0, 4'd6,  W_OREX},
        {6'b001101, 1'b1, 1'b0, 4'd7,  W_ORWB},
        {6'b100011, 1'b0, 1'b1, 4'd0,  W_IDLE},
        {6'b100011, 1'b0, 1'b1, 4'd0,  W_IDLE},
        {6'b100011, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b100011, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b100011, 1'b0, 1'b0, 4'd8,  W_ADEX},
        {6'b100011, 1'b0, 1'b1, 4'd9,  W_IDLE},
        {6'b100011, 1'b0, 1'b0, 4'd9,  W_LDMEM},
        {6'b100011, 1'b0, 1'b0, 4'd10, W_LDWB},
        {6'b101011, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b101011, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b101011, 1'b0, 1'b0, 4'd11, W_ADEX},
        {6'b101011, 1'b0, 1'b1, 4'd12, W_IDLE},
        {6'b101011, 1'b0, 1'b0, 4'd12, W_STMEM},
        {6'b000100, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b000100, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b000100, 1'b1, 1'b0, 4'd3,  W_BR1},
        {6'b000100, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b000100, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b000100, 1'b0, 1'b0, 4'd3,  W_BR0},
        {6'b111111, 1'b0, 1'b0, 4'd0,  W_FETCH},
        {6'b111111, 1'b0, 1'b0, 4'd1,  W_DEC},
        {6'b111111, 1'b0, 1'b0, 4'd0,  W_FETCH}
    };

    task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset upc", {11'd0, upc}, 15'd0);
        check("R1 reset word", cw, W_FETCH);
        @(negedge clk);
        rst = 1'b0;
        // R2 R3 R4 R5 R6 R7 R8 R9 trace table
        for (int i = 0; i < NV; i++) begin
            opcode   = VEC[i][26:21];
            eq       = VEC[i][20];
            mem_busy = VEC[i][19];
            #1;
            check($sformatf("R2/R3/R4/R6 upc step %0d", i), {11'd0, upc}, {11'd0, VEC[i][18:15]});
            check($sformatf("R5/R7/R8/R9 word step %0d", i), cw, VEC[i][14:0]);
            @(negedge clk);
        end
        // upc now 0001 with opcode 111111; steer to 0100 then reset mid-instruction
        opcode = 6'b000000;
        mem_busy = 1'b0;
        @(negedge clk);
        #1;
        check("R3 redispatch upc", {11'd0, upc}, 15'd4);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R1 mid-instruction reset upc", {11'd0, upc}, 15'd0);
        rst = 1'b0;
        // R6: long wait in fetch keeps upc
        mem_busy = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check("R6 long wait upc", {11'd0, upc}, 15'd0);
        check("R7 long wait word", cw, W_IDLE);
        mem_busy = 1'b0;
        @(negedge clk);
        #1;
        check("R2 after wait upc", {11'd0, upc}, 15'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule